// File: doc/BRIEF.md
# Selectable-Rate Sinc4 Decimation Filter

This block turns the one-bit stream of a delta-sigma modulator into signed multi-bit samples. It divides the master clock to produce the modulator sampling strobe. It runs four cascaded integrators at that strobe rate and four cascaded differentiators at the decimated rate, so the result is a fourth-order sinc response. Every notch therefore has four coincident zeros. The notches sit at every multiple of the output rate, and the whole response repeats at multiples of the modulator sampling rate.

A static pin picks one of two decimation ratios, eight times apart. Low selects the slow ratio; with a 4.9152 MHz master clock and a divide-by-64 strobe, this gives 10 outputs per second with nulls at every multiple of 10 Hz, so mains interference at both 50 Hz and 60 Hz is rejected. High selects the fast ratio, 80 outputs per second with nulls at multiples of 80 Hz. Rates and notches scale with the master clock; 6.144 MHz in fast mode gives 100 outputs per second. The output word keeps the same scaling in both modes. Any change of the pin restarts the filter from an empty state.

Top module: `sinc4_decimator`

## Requirements
- R1: `mod_stb` is high for exactly one clock in every CLK_DIV clocks. `mod_bit` is sampled on each clock edge at which `mod_stb` is high.
- R2: A sampled 1 counts as +1 and a 0 counts as −1. With the slow ratio RATIO_LOW, the full-scale code is FS = floor(RATIO_LOW^4 / 2^(ACC_W−OUT_W)). A settled all-ones input gives FS, and a settled all-zeros input gives −FS.
- R3: Consider an input whose pattern repeats with a period P that divides the active ratio and contains n1 ones and n0 zeros. Its settled output is FS·(n1−n0)/P. An alternating 1/0 input gives exactly 0.
- R4: With `rate_sel` = 0, a result is produced every RATIO_LOW strobes. With `rate_sel` = 1, a result is produced every RATIO_LOW/8 strobes. Consecutive `out_valid` pulses are therefore ratio·CLK_DIV clocks apart.
- R5: `out_valid` lasts one clock. `out_word` holds its value until the next pulse.
- R6: After reset, `out_valid` and `out_word` are 0. The first four decimation instants are suppressed, so the first pulse comes at the fifth.
- R7: A change of `rate_sel` clears every integrator, differentiator and the ratio counter. Suppression then restarts: no pulse comes within four periods of the new ratio.
- R8: In fast mode the differentiator result is multiplied by 2^12 before truncation. The fast-mode full-scale code is therefore the same FS as in slow mode.
- R9: The accumulators are ACC_W = 4·ceil(log2 RATIO_LOW)+2 bits wide and use wraparound arithmetic. `out_word` is the top OUT_W bits, rounded toward minus infinity, and always lies within ±FS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 1 | Ratio select: 0 slow, 1 fast (eight times faster) |
| mod_bit | input | 1 | Modulator output bit |
| mod_stb | output | 1 | Modulator sampling strobe |
| out_word | output | OUT_W | Signed filtered result |
| out_valid | output | 1 | One-clock strobe marking a new result |

## Verification
The in-line properties watch every clock for the following:
- the spacing between strobes;
- the spacing between decimation instants in strobes;
- single-cycle valid pulses;
- the absence of a pulse right after any clear;
- the integrators being empty after a clear;
- results staying within ±FS.

The numeric filter response cannot be seen by a property; only the bench's scenarios show it. Those scenarios cover:
- the ±FS codes;
- fractional duty patterns;
- the zero from alternating input;
- equal scaling in both modes;
- the five-period settling delay, both after reset and after a ratio switch.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;
  localparam int ORDER          = 4;
  localparam int RATE_STEP_LOG2 = 3;                  // fast ratio = slow / 8
  localparam int FAST_GAIN_SH   = ORDER * RATE_STEP_LOG2;

  typedef enum logic {RATE_SLOW = 1'b0, RATE_FAST = 1'b1} rate_e;

  function automatic int acc_width(input int ratio);
    return ORDER * $clog2(ratio) + 2;
  endfunction

  // one modulator bit as a two-bit signed step: 1 -> +1, 0 -> -1
  function automatic logic signed [1:0] bit_to_step(input logic b);
    return b ? 2'sb01 : 2'sb11;
  endfunction
endpackage

// File: rtl/sinc4_strobe_gen.sv
module sinc4_strobe_gen #(
  parameter int CLK_DIV = 64
) (
  input  logic clk,
  input  logic rst,
  output logic stb
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      stb   <= 1'b0;
    end else if (div_q == LAST) begin
      div_q <= '0;
      stb   <= 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
      stb   <= 1'b0;
    end
  end

  // checker: clocks elapsed since the previous strobe
  logic [DIV_W:0] since_q;
  logic           seen_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (stb) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else begin
      since_q <= since_q + 1'b1;
    end
  end

  a_r1_strobe_gap: assert property (@(posedge clk) disable iff (rst)
    (stb && seen_q) |-> (since_q == (DIV_W+1)'(CLK_DIV - 1)));
endmodule

// File: rtl/sinc4_integrators.sv
module sinc4_integrators
  import sinc4_pkg::*;
#(
  parameter int ACC_W = 54
) (
  input  logic                    clk,
  input  logic                    clr,
  input  logic                    en,
  input  logic                    bit_in,
  output logic signed [ACC_W-1:0] acc_out
);
  logic signed [ACC_W-1:0] acc [ORDER];
  logic signed [1:0]       step;
  logic signed [ACC_W-1:0] step_ext;

  always_comb begin
    step     = bit_to_step(bit_in);
    step_ext = {{(ACC_W-2){step[1]}}, step};
  end

  // wraparound accumulation; the final difference stays exact modulo 2^ACC_W
  always_ff @(posedge clk) begin
    if (clr) begin
      for (int k = 0; k < ORDER; k++) acc[k] <= '0;
    end else if (en) begin
      acc[0] <= acc[0] + step_ext;
      for (int k = 1; k < ORDER; k++) acc[k] <= acc[k] + acc[k-1];
    end
  end

  assign acc_out = acc[ORDER-1];
endmodule

// File: rtl/sinc4_combs.sv
module sinc4_combs
  import sinc4_pkg::*;
#(
  parameter int ACC_W = 54
) (
  input  logic                    clk,
  input  logic                    clr,
  input  logic                    dec_stb,
  input  logic signed [ACC_W-1:0] x_in,
  output logic signed [ACC_W-1:0] y_next
);
  logic signed [ACC_W-1:0] hist [ORDER];
  logic signed [ACC_W-1:0] diff [ORDER];

  generate
    for (genvar k = 0; k < ORDER; k++) begin : g_stage
      if (k == 0) begin : g_first
        assign diff[k] = x_in - hist[k];
      end else begin : g_rest
        assign diff[k] = diff[k-1] - hist[k];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int k = 0; k < ORDER; k++) hist[k] <= '0;
    end else if (dec_stb) begin
      hist[0] <= x_in;
      for (int k = 1; k < ORDER; k++) hist[k] <= diff[k-1];
    end
  end

  assign y_next = diff[ORDER-1];
endmodule

// File: rtl/sinc4_decim_ctrl.sv
module sinc4_decim_ctrl
  import sinc4_pkg::*;
#(
  parameter int RATIO_LOW = 7680
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic fast,
  output logic dec_stb,
  output logic settled
);
  localparam int RATIO_HIGH = RATIO_LOW >> RATE_STEP_LOG2;
  localparam int CNT_W      = $clog2(RATIO_LOW);
  localparam int SET_W      = $clog2(ORDER + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic [SET_W-1:0] settle_q;

  assign last_cnt = fast ? CNT_W'(RATIO_HIGH - 1) : CNT_W'(RATIO_LOW - 1);
  assign dec_stb  = en && !clr && (cnt_q == last_cnt);
  assign settled  = (settle_q == SET_W'(ORDER));

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q    <= '0;
      settle_q <= '0;
    end else if (en) begin
      cnt_q <= (cnt_q == last_cnt) ? '0 : cnt_q + 1'b1;
      if (dec_stb && !settled) settle_q <= settle_q + 1'b1;
    end
  end

  // checker: strobes counted between decimation instants
  logic [CNT_W:0] en_since_q;
  logic           dec_seen_q;
  always_ff @(posedge clk) begin
    if (clr) begin
      en_since_q <= '0;
      dec_seen_q <= 1'b0;
    end else if (dec_stb) begin
      en_since_q <= '0;
      dec_seen_q <= 1'b1;
    end else if (en) begin
      en_since_q <= en_since_q + 1'b1;
    end
  end

  a_r4_decim_spacing: assert property (@(posedge clk) disable iff (rst)
    (dec_stb && dec_seen_q) |->
      (en_since_q == (fast ? (CNT_W+1)'(RATIO_HIGH - 1) : (CNT_W+1)'(RATIO_LOW - 1))));
endmodule

// File: rtl/sinc4_decimator.sv
module sinc4_decimator
  import sinc4_pkg::*;
#(
  parameter int CLK_DIV   = 64,
  parameter int RATIO_LOW = 7680,
  parameter int OUT_W     = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rate_sel,
  input  logic                    mod_bit,
  output logic                    mod_stb,
  output logic signed [OUT_W-1:0] out_word,
  output logic                    out_valid
);
  localparam int    ACC_W   = acc_width(RATIO_LOW);
  localparam int    TRUNC   = ACC_W - OUT_W;
  localparam longint FS_CODE = (longint'(RATIO_LOW) ** 4) >>> TRUNC;

  rate_e rate_q;
  logic  rate_changed;
  logic  clr;
  logic  fast;
  logic  dec_stb;
  logic  settled;
  logic signed [ACC_W-1:0] integ_out;
  logic signed [ACC_W-1:0] comb_out;

  // R8/R9: align fast-mode gain to slow mode, keep top bits (floor)
  function automatic logic signed [OUT_W-1:0] fold_to_word(
      input logic signed [ACC_W-1:0] v, input logic f);
    logic signed [ACC_W-1:0] a;
    a = f ? (v <<< FAST_GAIN_SH) : v;
    return a[ACC_W-1 -: OUT_W];
  endfunction

  assign rate_changed = (rate_e'(rate_sel) != rate_q);
  assign clr          = rst || rate_changed;
  assign fast         = (rate_q == RATE_FAST);

  always_ff @(posedge clk) begin
    if (rst) rate_q <= rate_e'(rate_sel);
    else     rate_q <= rate_e'(rate_sel);
  end

  sinc4_strobe_gen #(.CLK_DIV(CLK_DIV)) u_stb (
    .clk (clk),
    .rst (rst),
    .stb (mod_stb)
  );

  sinc4_integrators #(.ACC_W(ACC_W)) u_integ (
    .clk     (clk),
    .clr     (clr),
    .en      (mod_stb),
    .bit_in  (mod_bit),
    .acc_out (integ_out)
  );

  sinc4_decim_ctrl #(.RATIO_LOW(RATIO_LOW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .en      (mod_stb),
    .fast    (fast),
    .dec_stb (dec_stb),
    .settled (settled)
  );

  sinc4_combs #(.ACC_W(ACC_W)) u_comb (
    .clk     (clk),
    .clr     (clr),
    .dec_stb (dec_stb),
    .x_in    (integ_out),
    .y_next  (comb_out)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      out_word  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= dec_stb && settled;
      if (dec_stb && settled) out_word <= fold_to_word(comb_out, fast);
    end
  end

  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r6_no_valid_after_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> !out_valid);

  a_r7_integrators_cleared: assert property (@(posedge clk) disable iff (rst)
    rate_changed |=> (u_integ.acc[0] == '0 && u_integ.acc[ORDER-1] == '0));

  a_r9_within_full_scale: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (longint'(out_word) <= FS_CODE && longint'(out_word) >= -FS_CODE));
endmodule

// File: tb/sinc4_decimator_bench.sv
`timescale 1ns/1ps
module sinc4_decimator_bench;
  localparam int DIV = 4;
  localparam int RLO = 64;
  localparam int RHI = 8;
  localparam int OW  = 16;
  localparam int FS  = 16384;   // 64^4 / 2^(26-16)

  typedef struct packed {
    logic              fast;
    logic [7:0]        pat;
    logic [3:0]        len;
    logic signed [15:0] exp;
  } vec_t;

  // pattern bit 0 is sent first; expected = FS*(n1-n0)/len
  localparam vec_t VECS [10] = '{
    '{1'b0, 8'hFF, 4'd8,  16'sd16384},
    '{1'b0, 8'h00, 4'd8, -16'sd16384},
    '{1'b0, 8'h01, 4'd2,  16'sd0},
    '{1'b0, 8'h07, 4'd4,  16'sd8192},
    '{1'b1, 8'hFF, 4'd8,  16'sd16384},
    '{1'b1, 8'h00, 4'd8, -16'sd16384},
    '{1'b1, 8'h01, 4'd2,  16'sd0},
    '{1'b1, 8'h01, 4'd8, -16'sd12288},
    '{1'b1, 8'h7F, 4'd8,  16'sd12288},
    '{1'b0, 8'h03, 4'd8, -16'sd8192}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rate_sel = 1'b0;
  logic mod_bit;
  logic mod_stb;
  logic out_valid;
  logic signed [OW-1:0] out_word;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int idx     = 0;
  logic [7:0] pat = 8'hFF;
  int plen = 8;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sinc4_decimator #(.CLK_DIV(DIV), .RATIO_LOW(RLO), .OUT_W(OW)) u_sinc4_decimator (
    .clk (clk), .rst (rst), .rate_sel (rate_sel), .mod_bit (mod_bit),
    .mod_stb (mod_stb), .out_word (out_word), .out_valid (out_valid)
  );

  initial forever begin
    @(posedge clk);
    cyc <= cyc + 1;
    if (rst) idx <= 0;
    else if (mod_stb) idx <= idx + 1;
  end

  assign mod_bit = pat[idx % plen];

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_valid(input int limit, output bit got, output int at, output int val);
    got = 1'b0; at = 0; val = 0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (out_valid) begin
        got = 1'b1; at = cyc; val = out_word;
        break;
      end
    end
  endtask

  task automatic restart(input logic f, input logic [7:0] p, input int l);
    @(negedge clk);
    rst = 1'b1; rate_sel = f; pat = p; plen = l;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    bit got;
    int t0, t1, v0, v1, r, s0, s1;

    // reset state (R6)
    repeat (4) @(negedge clk);
    check("R6 reset valid", int'(out_valid), 0);
    check("R6 reset word", int'(out_word), 0);
    rst = 1'b0;

    // strobe spacing (R1)
    while (!mod_stb) @(negedge clk);
    s0 = cyc;
    @(negedge clk);
    check("R1 strobe width", int'(mod_stb), 0);
    while (!mod_stb) @(negedge clk);
    s1 = cyc;
    check("R1 strobe period", s1 - s0, DIV);

    // table of patterns
    for (int i = 0; i < 10; i++) begin
      r = VECS[i].fast ? RHI : RLO;
      restart(VECS[i].fast, VECS[i].pat, int'(VECS[i].len));
      t0 = cyc;
      wait_valid(6 * r * DIV + 20, got, t1, v0);
      check("R6 first result arrives", int'(got), 1);
      check("R6 no early result", int'((t1 - t0) >= 4 * r * DIV && (t1 - t0) <= 5 * r * DIV + 8), 1);
      check("R2 R3 R8 settled value", v0, int'(VECS[i].exp));
      @(negedge clk);
      check("R5 single-cycle valid", int'(out_valid), 0);
      check("R5 word held", int'(out_word), int'(VECS[i].exp));
      wait_valid(r * DIV + 20, got, t0, v1);
      check("R4 result spacing", t0 - t1, r * DIV);
      check("R3 R9 repeat value", v1, int'(VECS[i].exp));
    end

    // ratio switch restarts the filter (R7)
    restart(1'b0, 8'hFF, 8);
    wait_valid(6 * RLO * DIV + 20, got, t0, v0);
    @(negedge clk);
    rate_sel = 1'b1;
    t0 = cyc;
    wait_valid(6 * RHI * DIV + 20, got, t1, v0);
    check("R7 result after switch", int'(got), 1);
    check("R7 settle after switch", int'((t1 - t0) >= 4 * RHI * DIV && (t1 - t0) <= 5 * RHI * DIV + 8), 1);
    check("R8 fast full scale", v0, FS);
    @(negedge clk);
    rate_sel = 1'b0;
    t0 = cyc;
    wait_valid(6 * RLO * DIV + 20, got, t1, v0);
    check("R7 settle after switch back", int'((t1 - t0) >= 4 * RLO * DIV), 1);
    check("R9 slow full scale", v0, FS);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule